// File: doc/BRIEF.md
# ADC Conversion Sequencer and Register Interface

This block is the digital front end of an eight-input analog-to-digital converter on a small byte-wide peripheral bus. Software sees two registers. The control/status byte holds a power switch, a conversion clock choice, a three-bit input selector and a read-only "result ready" flag. The result byte holds the most recent conversion.

Every conversion is a fixed window of 32 conversion-clock ticks. When the window ends, the sample value of the chosen input is captured into the result byte and the ready flag is raised. A new window then opens straight away. Writing the control byte drops the flag and restarts the window. Reading the result byte while the flag is up does the same. If software leaves the flag alone, conversions keep running back to back and the result byte is refreshed after every window.

The analog converter itself is not part of this block. A bus of per-input sample values stands in for it. The slow oscillator and the charge pump are represented only by their enable outputs. The clock choice is made by picking which tick enable advances the window counter.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, and `pump_en` and `rc_osc_en` are low.
- R2: The control byte is at address 0x0E. Bit 7 is the ready flag and ignores writes. Bit 6 is the clock select, bit 5 is the power switch, and bits 2:0 are the input selector. Bits 4:3 read as 0 and ignore writes. The result byte is at 0x0F and ignores writes. Any other address reads 0x00.
- R3: When a conversion window completes, the sample of the latched input is stored in the result byte, and the ready flag reads 1 from the next cycle on. The window completes on the 32nd counted tick after it starts.
- R4: A write to the control byte clears the ready flag and restarts the 32-tick window, using the input selector value just written.
- R5: A result-byte read made while the ready flag is 1 clears the flag and restarts the window. A result-byte read made while the flag is 0 changes nothing, and the running window completes on its original schedule.
- R6: If the ready flag is left at 1, a new window starts right after each completion. The result byte is overwritten every 32 ticks and the flag stays at 1.
- R7: Selector value n (0 to 7) captures sample slot n. Slots 0 to 3 are the external inputs, 4 is the high reference, 5 is the low reference, and 6 and 7 are internal reference points.
- R8: While the power switch is 0, no conversion completes and `pump_en` is low. After the switch goes from 0 to 1, the sequencer waits SETTLE_TICKS clocks before the first window opens. With the default of 8, the flag rises 41 clocks after the write edge.
- R9: `pump_en` equals the power switch. `rc_osc_en` is high only when both the power switch and the clock select are 1.
- R10: With clock select 0, the window advances on every clock. With clock select 1, it advances only on clocks where `rc_tick` is high.
- R11: If a result-byte read falls in the same cycle as a completion, the read returns the previous result. After that cycle the new result is stored and the flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| rc_tick | input | 1 | Tick enable from the slow oscillator |
| samp_data | input | NCH*8 | Per-input sample values, slot n at bits n*8 +: 8 |
| pump_en | output | 1 | Charge pump enable |
| rc_osc_en | output | 1 | Slow oscillator enable |

## Verification
The hardest case to reach is a result-byte read landing in the very cycle a window completes while the flag is already set. Clear and set then compete, and the read must still return the older value. The stimulus gets there by first letting the flag stay set through one full back-to-back window. Because every window length is known exactly, the read can then be scheduled for the cycle just before the next completion edge, with a fresh sample value already on the input. The slow-clock case is timed the same way: the bench drives `rc_tick` from the parity of its own cycle count, so the completion cycle depends on whether the write edge was odd or even.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BUS_W = 8;
    localparam int NCH   = 8;
    localparam int CH_W  = $clog2(NCH);

    localparam int FLAG_BIT = 7;
    localparam int CSEL_BIT = 6;
    localparam int PWR_BIT  = 5;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SETTLE,
        ST_CONV
    } seq_state_e;

    typedef struct packed {
        logic            ready;
        logic            csel;
        logic            pwr;
        logic [CH_W-1:0] sel;
    } ctrl_t;

    function automatic logic [BUS_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [BUS_W-1:0] b;
        b           = '0;
        b[FLAG_BIT] = c.ready;
        b[CSEL_BIT] = c.csel;
        b[PWR_BIT]  = c.pwr;
        b[CH_W-1:0] = c.sel;
        return b;
    endfunction

endpackage

// File: rtl/adc_seq_chmux.sv
module adc_seq_chmux
    import adc_seq_pkg::*;
#(
    parameter int SLOTS = NCH,
    parameter int DW    = BUS_W
) (
    input  logic [SLOTS*DW-1:0]       samp_flat,
    input  logic [$clog2(SLOTS)-1:0]  pick,
    output logic [DW-1:0]             picked
);

    logic [DW-1:0] slot [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign slot[i] = samp_flat[i*DW +: DW];
    end

    assign picked = slot[pick];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_TICKS = 8,
    parameter int CONV_TICKS   = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_i,
    input  logic            csel_i,
    input  logic            rc_tick_i,
    input  logic            restart_i,
    input  logic [CH_W-1:0] restart_sel_i,
    input  logic [CH_W-1:0] cur_sel_i,
    output logic            done_o,
    output logic [CH_W-1:0] conv_sel_o
);

    localparam int SPAN = (SETTLE_TICKS > CONV_TICKS) ? SETTLE_TICKS : CONV_TICKS;
    localparam int CW   = $clog2(SPAN + 1);
    localparam logic [CW-1:0] LAST_TICK  = CW'(CONV_TICKS - 1);
    localparam logic [CW-1:0] SETTLE_TOP = CW'(SETTLE_TICKS - 1);

    seq_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic            tick;

    assign tick   = csel_i ? rc_tick_i : 1'b1;
    assign done_o = (state_q == ST_CONV) && pwr_i && tick && (cnt_q == LAST_TICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_OFF;
            cnt_q      <= '0;
            conv_sel_o <= '0;
        end else if (!pwr_i) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_q <= ST_SETTLE;
                    cnt_q   <= SETTLE_TOP;
                end
                ST_SETTLE: begin
                    if (cnt_q == '0) begin
                        state_q    <= ST_CONV;
                        conv_sel_o <= cur_sel_i;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_CONV: begin
                    if (restart_i) begin
                        cnt_q      <= '0;
                        conv_sel_o <= restart_sel_i;
                    end else if (tick) begin
                        if (cnt_q == LAST_TICK) begin
                            cnt_q      <= '0;
                            conv_sel_o <= cur_sel_i;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_OFF;
            endcase
        end
    end

    AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pwr_i |=> state_q == ST_OFF); // R8

    AST_SETTLE_FIRST: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_OFF |=> state_q != ST_CONV); // R8

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_CONV |-> cnt_q <= LAST_TICK); // R3

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0E,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              done_i,
    input  logic [BUS_W-1:0]  sample_i,
    output logic              pwr_o,
    output logic              csel_o,
    output logic [CH_W-1:0]   sel_o,
    output logic              restart_o,
    output logic [CH_W-1:0]   restart_sel_o
);

    ctrl_t             ctrl_q;
    logic [BUS_W-1:0]  result_q;
    logic              ctrl_wr;
    logic              result_rd;
    logic              unused_wbits;

    assign ctrl_wr       = bus_wr && (bus_addr == CTRL_ADDR);
    assign result_rd     = bus_rd && (bus_addr == DATA_ADDR);
    assign restart_o     = ctrl_wr || (result_rd && ctrl_q.ready);
    assign restart_sel_o = ctrl_wr ? bus_wdata[CH_W-1:0] : ctrl_q.sel;
    assign unused_wbits  = ^{bus_wdata[FLAG_BIT], bus_wdata[PWR_BIT-1:CH_W]};

    assign pwr_o  = ctrl_q.pwr;
    assign csel_o = ctrl_q.csel;
    assign sel_o  = ctrl_q.sel;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata = ctrl_to_byte(ctrl_q);
        end else if (bus_addr == DATA_ADDR) begin
            bus_rdata = result_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            result_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.csel <= bus_wdata[CSEL_BIT];
                ctrl_q.pwr  <= bus_wdata[PWR_BIT];
                ctrl_q.sel  <= bus_wdata[CH_W-1:0];
            end
            if (done_i) begin
                ctrl_q.ready <= 1'b1;
                result_q     <= sample_i;
            end else if (ctrl_wr || result_rd) begin
                ctrl_q.ready <= 1'b0;
            end
        end
    end

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        done_i |=> ctrl_q.ready); // R3

    AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !done_i) |=> !ctrl_q.ready); // R4

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !done_i |=> $stable(result_q)); // R6

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR    = 8'h0E,
    parameter logic [ADDR_W-1:0] DATA_ADDR    = 8'h0F,
    parameter int                SETTLE_TICKS = 8,
    parameter int                CONV_TICKS   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic                  rc_tick,
    input  logic [NCH*BUS_W-1:0]  samp_data,
    output logic                  pump_en,
    output logic                  rc_osc_en
);

    logic            pwr;
    logic            csel;
    logic [CH_W-1:0] sel;
    logic            restart;
    logic [CH_W-1:0] restart_sel;
    logic            done;
    logic [CH_W-1:0] conv_sel;
    logic [BUS_W-1:0] sample;

    adc_seq_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_regs (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .done_i        (done),
        .sample_i      (sample),
        .pwr_o         (pwr),
        .csel_o        (csel),
        .sel_o         (sel),
        .restart_o     (restart),
        .restart_sel_o (restart_sel)
    );

    adc_seq_timer #(
        .SETTLE_TICKS (SETTLE_TICKS),
        .CONV_TICKS   (CONV_TICKS)
    ) u_timer (
        .clk           (clk),
        .rst           (rst),
        .pwr_i         (pwr),
        .csel_i        (csel),
        .rc_tick_i     (rc_tick),
        .restart_i     (restart),
        .restart_sel_i (restart_sel),
        .cur_sel_i     (sel),
        .done_o        (done),
        .conv_sel_o    (conv_sel)
    );

    adc_seq_chmux #(
        .SLOTS (NCH),
        .DW    (BUS_W)
    ) u_mux (
        .samp_flat (samp_data),
        .pick      (conv_sel),
        .picked    (sample)
    );

    assign pump_en   = pwr;
    assign rc_osc_en = pwr && csel;

    AST_OSC_NEEDS_PUMP: assert property (@(posedge clk) disable iff (rst)
        rc_osc_en |-> pump_en); // R9

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

    localparam int S  = 8;
    localparam int CT = 32;
    localparam logic [7:0] A_CTRL = 8'h0E;
    localparam logic [7:0] A_DATA = 8'h0F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rc_tick;
    logic [63:0] samp_data;
    logic        pump_en;
    logic        rc_osc_en;

    logic [7:0]  samp_v [8];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done_run = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rc_tick = cyc[0];

    always_comb begin
        for (int i = 0; i < 8; i++) samp_data[i*8 +: 8] = samp_v[i];
    end

    adc_seq_ctrl #(.SETTLE_TICKS(S), .CONV_TICKS(CT)) u_adc_seq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rc_tick   (rc_tick),
        .samp_data (samp_data),
        .pump_en   (pump_en),
        .rc_osc_en (rc_osc_en)
    );

    // monitor: pops expected read data and compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (bus_rd) begin
                n_checks++;
                if (sb_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard: read with nothing expected, got %02h expected none", bus_rdata);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    if (bus_rdata !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: cycle %0d read got %02h expected %02h",
                                 it.tag, cyc, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, output int edge_no);
        edge_no   = cyc + 1;
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wait_obs(input int m);
        while (cyc < m) @(negedge clk);
    endtask

    task automatic summary();
        if (!done_run) begin
            done_run = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary();
    end

    initial begin
        int w;
        int m;
        int f;
        int fe;
        for (int i = 0; i < 8; i++) samp_v[i] = 8'h11 * (i + 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, 8'h00, "R1");
        rd(A_DATA, 8'h00, "R1");
        chk(pump_en, 1'b0, "R1");
        chk(rc_osc_en, 1'b0, "R1");

        // R2 layout: bit7 and bits 4:3 ignore writes, result byte read-only
        wr(A_CTRL, 8'h9A, w);
        rd(A_CTRL, 8'h02, "R2");
        wr(A_DATA, 8'h55, w);
        rd(A_DATA, 8'h00, "R2");
        rd(8'h05, 8'h00, "R2");
        wr(A_CTRL, 8'h40, w);
        rd(A_CTRL, 8'h40, "R2");
        chk(rc_osc_en, 1'b0, "R9");
        chk(pump_en, 1'b0, "R8");
        wait_obs(w + 40);
        rd(A_CTRL, 8'h40, "R8");

        // R8 settle then R3 first completion on slot 2
        wr(A_CTRL, 8'h22, w);
        chk(pump_en, 1'b1, "R9");
        chk(rc_osc_en, 1'b0, "R9");
        wait_obs(w + S + 32);
        rd(A_CTRL, 8'h22, "R8");
        rd(A_CTRL, 8'hA2, "R3");
        m = cyc;
        rd(A_DATA, 8'h33, "R3");
        rd(A_CTRL, 8'h22, "R5");
        wait_obs(m + 10);
        rd(A_DATA, 8'h33, "R5");
        wait_obs(m + 32);
        rd(A_CTRL, 8'h22, "R5");
        rd(A_CTRL, 8'hA2, "R5");
        f = m + 33;

        // R6 flag left set: refresh after 32 more ticks
        samp_v[2] = 8'hC3;
        wait_obs(f + 32);
        rd(A_CTRL, 8'hA2, "R6");
        samp_v[2] = 8'h5A;
        // R11 read in the completion cycle returns old value
        wait_obs(f + 63);
        rd(A_DATA, 8'hC3, "R11");
        rd(A_CTRL, 8'hA2, "R11");
        rd(A_DATA, 8'h5A, "R11");

        // R4 and R7 every selector value
        for (int ch = 0; ch < 8; ch++) begin
            wr(A_CTRL, 8'h20 | 8'(ch), w);
            rd(A_CTRL, 8'h20 | 8'(ch), "R4");
            wait_obs(w + 31);
            rd(A_CTRL, 8'h20 | 8'(ch), "R4");
            rd(A_CTRL, 8'hA0 | 8'(ch), "R4");
            rd(A_DATA, samp_v[ch], "R7");
        end

        // R10 slow clock: window advances only on rc_tick
        wr(A_CTRL, 8'h61, w);
        chk(rc_osc_en, 1'b1, "R9");
        fe = (w % 2 == 1) ? w + 63 : w + 64;
        wait_obs(fe - 1);
        rd(A_CTRL, 8'h61, "R10");
        rd(A_CTRL, 8'hE1, "R10");
        rd(A_DATA, samp_v[1], "R10");

        // R8 power off: no completion
        wr(A_CTRL, 8'h02, w);
        chk(pump_en, 1'b0, "R8");
        chk(rc_osc_en, 1'b0, "R9");
        wait_obs(w + 45);
        rd(A_CTRL, 8'h02, "R8");
        rd(A_DATA, samp_v[1], "R8");

        @(negedge clk);
        #4;
        summary();
    end

endmodule